// File: doc/BRIEF.md
# Auxiliary System Control Registers

This block is a cluster of small control registers for a workstation I/O companion device. A host reaches it over a simple synchronous register bus. The bus has a one-hot register select, a small address offset, a write enable and a write data word. Read data comes straight back from the selected register. The block holds a configuration byte, a diagnostic byte, a modem-control byte, two auxiliary bytes, a 16-bit LED word and a 32-bit system-control word.

Several bits act on the outside world rather than only being stored. One auxiliary byte fires a single-cycle floppy terminal-count strobe. The other auxiliary byte handles the power-fail status: it latches the status, clears it on command, and issues a one-cycle power-off request. A power-fail input level sets or clears the status latch, gated by an enable bit in the configuration byte. The latched status combined with that enable drives an interrupt. Writing the reset bit of the system-control word records a reset-status value and pulses a system-reset request.

Two resets exist. The power-on reset `rst` clears everything. The soft reset `soft_rst` clears only the configuration, modem-control and both auxiliary bytes, so the platform can still read why it restarted.

Top module: `auxctl_regs`

## Requirements
- R1: After power-on reset every register reads zero and pf_irq, tc_pulse, pwroff_req and sysrst_req are low.
- R2: The configuration (select bit 0), diagnostic (select bit 1) and modem-control (select bit 2) bytes are plain read/write storage. Their read data is zero-extended, and the offset does not matter.
- R3: The LED word (select bit 3) is 16 bits wide and is written and read only at offset 0. A write at another offset leaves it unchanged, and a read at another offset returns zero.
- R4: A write to auxiliary-1 (select bit 5) with data bit 1 set drives tc_pulse high for exactly the cycle after the write edge. The stored byte is the written byte with bit 1 forced to zero.
- R5: A write to auxiliary-2 (select bit 6) uses only data bits 0 and 1. The power-fail status (bit 5, value 0x20) is carried over unchanged.
- R6: An auxiliary-2 write with bit 1 (clear) set stores only bit 0 of the written data. This clears the power-fail status and drops pf_irq.
- R7: When the resulting auxiliary-2 bit 0 is set, pwroff_req pulses high for one cycle after the write edge.
- R8: When pf_in changes, the status bit becomes 1 if the new level is high and configuration bit 3 (value 0x08) is set. Otherwise it becomes 0.
- R9: pf_irq is high exactly when the status bit and configuration bit 3 are both set. A configuration write re-evaluates pf_irq without altering the status.
- R10: A system-control write (select bit 4) at offset 0 with data bit 0 set loads 0x02 and pulses sysrst_req for one cycle. A write without bit 0, or at another offset, is ignored. A read at a nonzero offset returns zero.
- R11: Soft reset clears the configuration, modem-control and both auxiliary bytes, and drops pf_irq. It keeps the diagnostic byte, the LED word and the system-control word.
- R12: When an auxiliary-2 write and a pf_in change fall in the same cycle, the input change is applied after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| soft_rst | input | 1 | Synchronous active-high soft reset (partial clear) |
| reg_sel | input | 7 | One-hot register select |
| reg_off | input | OFF_W (2) | Address offset within the selected register |
| reg_we | input | 1 | Write enable |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Combinational read data from the selected register |
| pf_in | input | 1 | Power-fail input level (synchronous) |
| pf_irq | output | 1 | Power-fail interrupt |
| tc_pulse | output | 1 | One-cycle floppy terminal-count strobe |
| pwroff_req | output | 1 | One-cycle power-off request |
| sysrst_req | output | 1 | One-cycle system-reset request |

## Verification
Two actions can touch the auxiliary-2 power-fail status in the same clock: a host write to auxiliary-2 and a change of the pf_in level. The bench provokes this collision by raising pf_in on the same falling edge at which it presents a write of the clear bit. Both take effect on the next rising edge. The collision is judged by reading auxiliary-2 back: it must show 0x20 and pf_irq must be high, because the input change overrides the clear. If the write had won, the register would read zero with the interrupt low.

// File: rtl/auxctl_pkg.sv
package auxctl_pkg;
  // register select positions on the one-hot select bus
  localparam int NREG     = 7;
  localparam int SEL_CFG  = 0;
  localparam int SEL_DIAG = 1;
  localparam int SEL_MDM  = 2;
  localparam int SEL_LED  = 3;
  localparam int SEL_SYS  = 4;
  localparam int SEL_AUX1 = 5;
  localparam int SEL_AUX2 = 6;

  localparam int BYTE_W = 8;

  // bit positions whose behaviour matters
  localparam int CFG_PIE_BIT  = 3;
  localparam int AUX1_TC_BIT  = 1;
  localparam int AUX2_OFF_BIT = 0;
  localparam int AUX2_CLR_BIT = 1;
  localparam int AUX2_PF_BIT  = 5;
  localparam int SYS_RST_BIT  = 0;

  localparam logic [BYTE_W-1:0] SYS_RSTSTAT = 8'h02;
endpackage

// File: rtl/auxctl_bytefile.sv
module auxctl_bytefile #(
  parameter int W = 8,
  parameter int N = 3,
  parameter logic [N-1:0] SOFT_CLR = '1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                soft_rst,
  input  logic [N-1:0]        wr,
  input  logic [W-1:0]        wdata,
  output logic [N-1:0][W-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_reg
    if (SOFT_CLR[i]) begin : g_clr
      always_ff @(posedge clk) begin
        if (rst || soft_rst) q[i] <= '0;
        else if (wr[i])      q[i] <= wdata;
      end
    end else begin : g_keep
      always_ff @(posedge clk) begin
        if (rst)        q[i] <= '0;
        else if (wr[i]) q[i] <= wdata;
      end
    end
  end
endmodule

// File: rtl/auxctl_strobe.sv
module auxctl_strobe
  import auxctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] aux1_q,
  output logic              tc_pulse
);
  logic [BYTE_W-1:0] stored;

  always_comb begin
    stored = wdata;
    stored[AUX1_TC_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      aux1_q   <= '0;
      tc_pulse <= 1'b0;
    end else begin
      tc_pulse <= wr && wdata[AUX1_TC_BIT];
      if (wr) aux1_q <= stored;
    end
  end
endmodule

// File: rtl/auxctl_power.sv
module auxctl_power
  import auxctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              wr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              pie_cur,
  input  logic              pie_nxt,
  input  logic              pf_in,
  output logic [BYTE_W-1:0] aux2_q,
  output logic              pf_irq,
  output logic              pwroff_req
);
  logic              pf_prev;
  logic [BYTE_W-1:0] wr_val;
  logic [BYTE_W-1:0] nxt;

  // value that a host write would leave, before input events
  always_comb begin
    wr_val = '0;
    wr_val[AUX2_OFF_BIT] = wdata[AUX2_OFF_BIT];
    wr_val[AUX2_CLR_BIT] = wdata[AUX2_CLR_BIT];
    wr_val[AUX2_PF_BIT]  = aux2_q[AUX2_PF_BIT];
    if (wr_val[AUX2_CLR_BIT]) begin
      wr_val = '0;
      wr_val[AUX2_OFF_BIT] = wdata[AUX2_OFF_BIT];
    end
  end

  // write first, then a level change of the power-fail input
  always_comb begin
    nxt = wr ? wr_val : aux2_q;
    if (pf_in != pf_prev) nxt[AUX2_PF_BIT] = pf_in && pie_cur;
    if (soft_rst) nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pf_prev    <= 1'b0;
      aux2_q     <= '0;
      pf_irq     <= 1'b0;
      pwroff_req <= 1'b0;
    end else begin
      pf_prev    <= pf_in;
      aux2_q     <= nxt;
      pf_irq     <= nxt[AUX2_PF_BIT] && pie_nxt;
      pwroff_req <= wr && !soft_rst && wr_val[AUX2_OFF_BIT];
    end
  end
endmodule

// File: rtl/auxctl_sysreg.sv
module auxctl_sysreg
  import auxctl_pkg::*;
#(
  parameter int OFF_W = 2,
  parameter int LED_W = 16,
  parameter int SYS_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_led,
  input  logic             wr_sys,
  input  logic [OFF_W-1:0] off,
  input  logic [LED_W-1:0] wdata_led,
  input  logic             wdata_rst,
  output logic [LED_W-1:0] led_q,
  output logic [SYS_W-1:0] sys_q,
  output logic             sysrst_req
);
  logic at_zero;
  assign at_zero = (off == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      led_q      <= '0;
      sys_q      <= '0;
      sysrst_req <= 1'b0;
    end else begin
      sysrst_req <= wr_sys && at_zero && wdata_rst;
      if (wr_led && at_zero) led_q <= wdata_led;
      if (wr_sys && at_zero && wdata_rst)
        sys_q <= {{(SYS_W-BYTE_W){1'b0}}, SYS_RSTSTAT};
    end
  end
endmodule

// File: rtl/auxctl_regs.sv
module auxctl_regs
  import auxctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 2,
  parameter int LED_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic [NREG-1:0]   reg_sel,
  input  logic [OFF_W-1:0]  reg_off,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              pf_in,
  output logic              pf_irq,
  output logic              tc_pulse,
  output logic              pwroff_req,
  output logic              sysrst_req
);
  localparam int NBYTE = 3;
  localparam logic [NBYTE-1:0] BYTE_SOFT = 3'b101; // cfg, mdm clear; diag kept

  logic [NREG-1:0]              wr;
  logic [NBYTE-1:0][BYTE_W-1:0] byte_q;
  logic [BYTE_W-1:0]            cfg_q, diag_q, mdm_q, aux1_q, aux2_q;
  logic [LED_W-1:0]             led_q;
  logic [DATA_W-1:0]            sys_q;
  logic                         pie_nxt;
  logic                         off_zero;

  assign wr       = reg_we ? reg_sel : '0;
  assign off_zero = (reg_off == '0);

  auxctl_bytefile #(.W(BYTE_W), .N(NBYTE), .SOFT_CLR(BYTE_SOFT)) u_bytes (
    .clk(clk), .rst(rst), .soft_rst(soft_rst),
    .wr(wr[SEL_MDM:SEL_CFG]), .wdata(reg_wdata[BYTE_W-1:0]), .q(byte_q)
  );
  assign cfg_q  = byte_q[SEL_CFG];
  assign diag_q = byte_q[SEL_DIAG];
  assign mdm_q  = byte_q[SEL_MDM];

  // enable as it will stand after this edge
  assign pie_nxt = !soft_rst &&
                   (wr[SEL_CFG] ? reg_wdata[CFG_PIE_BIT] : cfg_q[CFG_PIE_BIT]);

  auxctl_strobe u_aux1 (
    .clk(clk), .rst(rst), .soft_rst(soft_rst),
    .wr(wr[SEL_AUX1]), .wdata(reg_wdata[BYTE_W-1:0]),
    .aux1_q(aux1_q), .tc_pulse(tc_pulse)
  );

  auxctl_power u_aux2 (
    .clk(clk), .rst(rst), .soft_rst(soft_rst),
    .wr(wr[SEL_AUX2]), .wdata(reg_wdata[BYTE_W-1:0]),
    .pie_cur(cfg_q[CFG_PIE_BIT]), .pie_nxt(pie_nxt), .pf_in(pf_in),
    .aux2_q(aux2_q), .pf_irq(pf_irq), .pwroff_req(pwroff_req)
  );

  auxctl_sysreg #(.OFF_W(OFF_W), .LED_W(LED_W), .SYS_W(DATA_W)) u_sys (
    .clk(clk), .rst(rst),
    .wr_led(wr[SEL_LED]), .wr_sys(wr[SEL_SYS]), .off(reg_off),
    .wdata_led(reg_wdata[LED_W-1:0]), .wdata_rst(reg_wdata[SYS_RST_BIT]),
    .led_q(led_q), .sys_q(sys_q), .sysrst_req(sysrst_req)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_sel[SEL_CFG])  reg_rdata = reg_rdata | DATA_W'(cfg_q);
    if (reg_sel[SEL_DIAG]) reg_rdata = reg_rdata | DATA_W'(diag_q);
    if (reg_sel[SEL_MDM])  reg_rdata = reg_rdata | DATA_W'(mdm_q);
    if (reg_sel[SEL_AUX1]) reg_rdata = reg_rdata | DATA_W'(aux1_q);
    if (reg_sel[SEL_AUX2]) reg_rdata = reg_rdata | DATA_W'(aux2_q);
    if (reg_sel[SEL_LED] && off_zero) reg_rdata = reg_rdata | DATA_W'(led_q);
    if (reg_sel[SEL_SYS] && off_zero) reg_rdata = reg_rdata | sys_q;
  end
endmodule

// File: rtl/auxctl_regs_chk.sv
module auxctl_regs_chk
  import auxctl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              soft_rst,
  input logic [NREG-1:0]   reg_sel,
  input logic              reg_we,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              pf_irq,
  input logic              tc_pulse,
  input logic              pwroff_req,
  input logic              sysrst_req,
  input logic [BYTE_W-1:0] cfg_q,
  input logic [BYTE_W-1:0] mdm_q,
  input logic [BYTE_W-1:0] aux1_q,
  input logic [BYTE_W-1:0] aux2_q,
  input logic [DATA_W-1:0] sys_q
);
  AST_IRQ_GATING: assert property (@(posedge clk) disable iff (rst)
    pf_irq == (aux2_q[AUX2_PF_BIT] && cfg_q[CFG_PIE_BIT])); // R9

  AST_TC_CAUSE: assert property (@(posedge clk) disable iff (rst)
    tc_pulse |-> $past(reg_sel[SEL_AUX1] && reg_we && reg_wdata[AUX1_TC_BIT])); // R4

  AST_AUX1_NO_TC_BIT: assert property (@(posedge clk) disable iff (rst)
    $past(reg_sel[SEL_AUX1] && reg_we) |-> !aux1_q[AUX1_TC_BIT]); // R4

  AST_AUX2_FIELDS: assert property (@(posedge clk) disable iff (rst)
    (aux2_q & ~8'h21) == 8'h00); // R5

  AST_PWROFF_CAUSE: assert property (@(posedge clk) disable iff (rst)
    pwroff_req |-> $past(reg_sel[SEL_AUX2] && reg_we && reg_wdata[AUX2_OFF_BIT])); // R7

  AST_SYSRST_STATUS: assert property (@(posedge clk) disable iff (rst)
    sysrst_req |-> sys_q == DATA_W'(SYS_RSTSTAT)); // R10

  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(soft_rst) |-> (cfg_q == 0 && mdm_q == 0 && aux1_q == 0 && aux2_q == 0 && !pf_irq)); // R11
endmodule

bind auxctl_regs auxctl_regs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .soft_rst(soft_rst), .reg_sel(reg_sel), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .pf_irq(pf_irq), .tc_pulse(tc_pulse),
  .pwroff_req(pwroff_req), .sysrst_req(sysrst_req), .cfg_q(cfg_q),
  .mdm_q(mdm_q), .aux1_q(aux1_q), .aux2_q(aux2_q), .sys_q(sys_q)
);

// File: tb/auxctl_regs_test.sv
`timescale 1ns/1ps
module auxctl_regs_test;
  localparam int NR = 7;
  localparam int CFG = 0, DIAG = 1, MDM = 2, LED = 3, SYS = 4, AUX1 = 5, AUX2 = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        soft_rst = 1'b0;
  logic [NR-1:0] reg_sel = '0;
  logic [1:0]  reg_off = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pf_in = 1'b0;
  logic        pf_irq, tc_pulse, pwroff_req, sysrst_req;

  int n_chk = 0;
  int n_bad = 0;
  logic s_tc, s_off, s_rst;

  always #10 clk = ~clk;

  auxctl_regs uut (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .reg_sel(reg_sel),
    .reg_off(reg_off), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pf_in(pf_in), .pf_irq(pf_irq),
    .tc_pulse(tc_pulse), .pwroff_req(pwroff_req), .sysrst_req(sysrst_req)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(int idx, int off, logic [31:0] d);
    reg_sel = NR'(1) << idx; reg_off = 2'(off); reg_we = 1'b1; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    s_tc = tc_pulse; s_off = pwroff_req; s_rst = sysrst_req;
    reg_sel = '0; reg_we = 1'b0; reg_wdata = '0; reg_off = '0;
  endtask

  task automatic rd(int idx, int off, output logic [31:0] v);
    reg_sel = NR'(1) << idx; reg_off = 2'(off); reg_we = 1'b0;
    #2 v = reg_rdata;
    reg_sel = '0; reg_off = '0;
  endtask

  task automatic idle(); @(negedge clk); endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int i = 0; i < NR; i++) begin rd(i, 0, v); check("R1 reg zero", v, 0); end
    check("R1 outputs low", {pf_irq, tc_pulse, pwroff_req, sysrst_req}, 0);
  endtask

  task automatic t_plain();
    logic [31:0] v;
    wr(CFG, 0, 32'hFFFF_FF81); rd(CFG, 2, v); check("R2 cfg", v, 32'h81);
    wr(DIAG, 3, 32'h5A);       rd(DIAG, 0, v); check("R2 diag", v, 32'h5A);
    wr(MDM, 1, 32'hC3);        rd(MDM, 1, v);  check("R2 mdm", v, 32'hC3);
    wr(CFG, 0, 0);
  endtask

  task automatic t_led();
    logic [31:0] v;
    wr(LED, 0, 32'h1234_BEEF); rd(LED, 0, v); check("R3 led write", v, 32'hBEEF);
    wr(LED, 1, 32'h0000_1111); rd(LED, 0, v); check("R3 led off1 ignored", v, 32'hBEEF);
    rd(LED, 2, v); check("R3 led read off2", v, 0);
  endtask

  task automatic t_aux1();
    logic [31:0] v;
    wr(AUX1, 0, 32'hF3);
    check("R4 tc pulse high", s_tc, 1);
    rd(AUX1, 0, v); check("R4 aux1 stored", v, 32'hF1);
    idle(); check("R4 tc one cycle", tc_pulse, 0);
    wr(AUX1, 0, 32'h84); check("R4 no tc", s_tc, 0);
    rd(AUX1, 0, v); check("R4 aux1 plain", v, 32'h84);
  endtask

  task automatic t_pf_input();
    logic [31:0] v;
    wr(CFG, 0, 32'h08);
    pf_in = 1'b1; idle();
    check("R8 irq set", pf_irq, 1);
    rd(AUX2, 0, v); check("R8 status set", v, 32'h20);
    wr(CFG, 0, 32'h00);
    check("R9 irq off with enable clear", pf_irq, 0);
    rd(AUX2, 0, v); check("R9 status kept", v, 32'h20);
    wr(CFG, 0, 32'h08);
    check("R9 irq back", pf_irq, 1);
    wr(CFG, 0, 32'h00);
    pf_in = 1'b0; idle();
    rd(AUX2, 0, v); check("R8 falling clears", v, 0);
    pf_in = 1'b1; idle();
    rd(AUX2, 0, v); check("R8 no enable no set", v, 0);
    check("R8 irq stays low", pf_irq, 0);
    pf_in = 1'b0; idle();
  endtask

  task automatic t_aux2();
    logic [31:0] v;
    wr(CFG, 0, 32'h08);
    pf_in = 1'b1; idle();
    wr(AUX2, 0, 32'hFC);
    rd(AUX2, 0, v); check("R5 mask and carry", v, 32'h20);
    check("R5 no pwroff", s_off, 0);
    wr(AUX2, 0, 32'h01);
    check("R7 pwroff pulse", s_off, 1);
    rd(AUX2, 0, v); check("R7 aux2 value", v, 32'h21);
    idle(); check("R7 pwroff one cycle", pwroff_req, 0);
    wr(AUX2, 0, 32'h02);
    rd(AUX2, 0, v); check("R6 clear status", v, 0);
    check("R6 irq dropped", pf_irq, 0);
    check("R6 no pwroff", s_off, 0);
    wr(AUX2, 0, 32'h03);
    rd(AUX2, 0, v); check("R6 keep bit0 only", v, 32'h01);
    check("R7 pwroff with clear", s_off, 1);
    pf_in = 1'b0; idle();
    wr(AUX2, 0, 0);
  endtask

  task automatic t_same_cycle();
    logic [31:0] v;
    wr(CFG, 0, 32'h08);
    pf_in = 1'b1;
    wr(AUX2, 0, 32'h02);
    rd(AUX2, 0, v); check("R12 input after write", v, 32'h20);
    check("R12 irq high", pf_irq, 1);
    pf_in = 1'b0; idle();
    wr(AUX2, 0, 0);
  endtask

  task automatic t_sys();
    logic [31:0] v;
    wr(SYS, 0, 32'hFFFF_FFFE); rd(SYS, 0, v); check("R10 no bit0 ignored", v, 0);
    check("R10 no reset req", s_rst, 0);
    wr(SYS, 1, 32'h1); rd(SYS, 0, v); check("R10 off1 ignored", v, 0);
    check("R10 off1 no req", s_rst, 0);
    wr(SYS, 0, 32'h0000_0005); check("R10 reset req", s_rst, 1);
    rd(SYS, 0, v); check("R10 status loaded", v, 32'h2);
    rd(SYS, 3, v); check("R10 read off3", v, 0);
    idle(); check("R10 req one cycle", sysrst_req, 0);
  endtask

  task automatic t_soft();
    logic [31:0] v;
    wr(CFG, 0, 32'h08); wr(MDM, 0, 32'h33); wr(AUX1, 0, 32'h80);
    pf_in = 1'b1; idle();
    check("R11 irq before", pf_irq, 1);
    soft_rst = 1'b1; idle(); soft_rst = 1'b0;
    rd(CFG, 0, v);  check("R11 cfg cleared", v, 0);
    rd(MDM, 0, v);  check("R11 mdm cleared", v, 0);
    rd(AUX1, 0, v); check("R11 aux1 cleared", v, 0);
    rd(AUX2, 0, v); check("R11 aux2 cleared", v, 0);
    check("R11 irq low", pf_irq, 0);
    rd(DIAG, 0, v); check("R11 diag kept", v, 32'h5A);
    rd(SYS, 0, v);  check("R11 sys kept", v, 32'h2);
    rd(LED, 0, v);  check("R11 led kept", v, 32'hBEEF);
    pf_in = 1'b0; idle();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle();
    t_reset();
    t_plain();
    t_led();
    t_aux1();
    t_pf_input();
    t_aux2();
    t_same_cycle();
    t_sys();
    t_soft();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule